// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is a single memory-to-memory DMA channel. Software loads a source address, a destination address, a pointer to the next descriptor, a control word and a channel configuration word through a small register port. Once the channel is enabled, it copies one item at a time. Each element is read from the source and then written to the destination over a valid/ready memory master port. The port has one request in flight at a time, and responses return in order.

When an item's element count reaches zero, the channel checks the next-descriptor pointer. If the pointer is non-zero, the channel reads a four-word descriptor from it straight into its working registers and carries on. If the pointer is zero, the chain is over: the channel clears its own enable bit and goes idle. One-cycle terminal-count and error pulses go to an external interrupt unit.

Back-pressure works as follows. A request stays on `mem_req_*` with `mem_req_valid` high until the cycle in which `mem_req_ready` is high, and its fields do not change while it waits. The memory side returns exactly one response per accepted request, flagged by `mem_rsp_valid`, and never before the cycle after acceptance. The channel always accepts a response.

Top module: `lldma_channel`

## Requirements
- R1: After reset every register reads zero. Register read data is combinational from `reg_addr`, and a write takes effect at the clock edge where `reg_we` is high. The register offsets are:
  - 0: controller enable (bit 0).
  - 1: source address.
  - 2: destination address.
  - 3: next pointer.
  - 4: control word.
  - 5: channel configuration. Bit 0 is the enable, bit 17 is the read-only busy flag and bit 18 is the halt request.
- R2: Each element is moved by one read and one write. The read is sent to the source address with size set to the source width code (control bits 20:18). The write is sent to the destination address with size set to the destination width code (bits 23:21). The width codes are 0 = byte, 1 = halfword and 2 = word. Data travels in the low bits of the bus. The write data is the read element, zero-extended and then cut to the destination width.
- R3: After each element, the channel moves the source address on by its own element size in bytes if control bit 26 is set, and the destination address likewise if bit 27 is set. An address whose bit is clear stays fixed. The count in control bits 10:0 goes down by one per element. Registers 1, 2 and 4 read back the updated values.
- R4: When the count is zero and the next pointer P is non-zero, the channel reads four words at P, P+4, P+8 and P+12. These are loaded in that order into source, destination, next pointer and control. When the count is zero and P is zero, the channel clears its enable and goes idle.
- R5: When an item completes and control bit 31 is set, `tc_pulse` is high for one cycle. This also applies to an item whose count was zero from the start.
- R6: A width code above 2 is caught when an item starts. The channel then pulses `err_pulse`, clears its enable and issues no memory request.
- R7: An error response to any request pulses `err_pulse`, clears the enable and stops the channel. After a failed source read, no write follows.
- R8: While halt is set, the channel finishes the element or descriptor already in progress and starts no new one, and the busy flag reads 0. When halt is cleared, the channel resumes where it stopped.
- R9: While the controller enable is 0, no channel request is started.
- R10: If software clears the channel enable in the middle of an item, the channel completes the element in flight and goes idle. The registers keep the remaining count and the current addresses.
- R11: A request that has not been accepted keeps `mem_req_valid` high and its address and direction unchanged. `tc_pulse` and `err_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address |
| mem_req_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_req_wdata | output | 32 | Write data, low-aligned |
| mem_rsp_valid | input | 1 | Response for the oldest accepted request |
| mem_rsp_data | input | 32 | Read data, low-aligned |
| mem_rsp_err | input | 1 | Response carries a bus error |
| tc_pulse | output | 1 | Item completed with terminal-count request |
| err_pulse | output | 1 | Channel stopped on an error |

## Verification
A wrong sequencer state shows up at the memory port within one request. Typical signs are a request that is dropped or changed while waiting, a write with no read before it, or a request while halted. Address-step or count faults only show in the destination memory image and in the register readback once the item ends, so every run compares the complete memory image with an arithmetic model. Faults in descriptor loading surface at the next item, as wrong addresses, a wrong terminal-count total or a chain that never ends.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int RA_W  = 3;
  localparam int CNT_W = 11;

  localparam logic [RA_W-1:0] REG_GLB = 3'd0;
  localparam logic [RA_W-1:0] REG_SRC = 3'd1;
  localparam logic [RA_W-1:0] REG_DST = 3'd2;
  localparam logic [RA_W-1:0] REG_NXT = 3'd3;
  localparam logic [RA_W-1:0] REG_CTL = 3'd4;
  localparam logic [RA_W-1:0] REG_CFG = 3'd5;

  localparam int CTL_TC   = 31;
  localparam int CTL_DINC = 27;
  localparam int CTL_SINC = 26;
  localparam int CTL_DW_L = 21;
  localparam int CTL_SW_L = 18;
  localparam int CFG_EN   = 0;
  localparam int CFG_BUSY = 17;
  localparam int CFG_HALT = 18;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCHED, ST_RD, ST_RDW, ST_WR, ST_WRW, ST_FQ, ST_FW
  } lldma_state_e;

  function automatic logic [31:0] width_mask(input logic [1:0] w);
    case (w)
      2'd0:    width_mask = 32'h0000_00FF;
      2'd1:    width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/lldma_step.sv
module lldma_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    width_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  assign addr_o = inc_i ? addr_i + (AW'(1) << width_i) : addr_i;
endmodule

// File: rtl/lldma_regs.sv
module lldma_regs
  import lldma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             src_upd,
  input  logic [AW-1:0]    src_nxt,
  input  logic             dst_upd,
  input  logic [AW-1:0]    dst_nxt,
  input  logic             cnt_upd,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             ld_valid,
  input  logic [1:0]       ld_idx,
  input  logic [31:0]      ld_data,
  input  logic             clr_en,
  input  logic             active,
  output logic [AW-1:0]    src_q,
  output logic [AW-1:0]    dst_q,
  output logic [AW-1:0]    nxt_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [2:0]       sw_q,
  output logic [2:0]       dw_q,
  output logic             sinc_q,
  output logic             dinc_q,
  output logic             tc_q,
  output logic             ch_en,
  output logic             ch_halt,
  output logic             glb_en
);
  logic [31:0] ctl_q;
  logic        wr_glb, wr_src, wr_dst, wr_nxt, wr_ctl, wr_cfg;

  assign wr_glb = reg_we && reg_addr == REG_GLB;
  assign wr_src = reg_we && reg_addr == REG_SRC;
  assign wr_dst = reg_we && reg_addr == REG_DST;
  assign wr_nxt = reg_we && reg_addr == REG_NXT;
  assign wr_ctl = reg_we && reg_addr == REG_CTL;
  assign wr_cfg = reg_we && reg_addr == REG_CFG;

  // Engine updates take priority over software writes in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      nxt_q   <= '0;
      ctl_q   <= '0;
      ch_en   <= 1'b0;
      ch_halt <= 1'b0;
      glb_en  <= 1'b0;
    end else begin
      if (wr_glb) glb_en <= reg_wdata[0];
      if (wr_cfg) begin
        ch_en   <= reg_wdata[CFG_EN];
        ch_halt <= reg_wdata[CFG_HALT];
      end
      if (clr_en) ch_en <= 1'b0;

      if (wr_src) src_q <= reg_wdata[AW-1:0];
      if (src_upd) src_q <= src_nxt;
      if (ld_valid && ld_idx == 2'd0) src_q <= ld_data[AW-1:0];

      if (wr_dst) dst_q <= reg_wdata[AW-1:0];
      if (dst_upd) dst_q <= dst_nxt;
      if (ld_valid && ld_idx == 2'd1) dst_q <= ld_data[AW-1:0];

      if (wr_nxt) nxt_q <= reg_wdata[AW-1:0];
      if (ld_valid && ld_idx == 2'd2) nxt_q <= ld_data[AW-1:0];

      if (wr_ctl) ctl_q <= reg_wdata;
      if (cnt_upd) ctl_q[CNT_W-1:0] <= cnt_nxt;
      if (ld_valid && ld_idx == 2'd3) ctl_q <= ld_data;
    end
  end

  assign cnt_q  = ctl_q[CNT_W-1:0];
  assign sw_q   = ctl_q[CTL_SW_L +: 3];
  assign dw_q   = ctl_q[CTL_DW_L +: 3];
  assign sinc_q = ctl_q[CTL_SINC];
  assign dinc_q = ctl_q[CTL_DINC];
  assign tc_q   = ctl_q[CTL_TC];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_GLB: reg_rdata[0] = glb_en;
      REG_SRC: reg_rdata = 32'(src_q);
      REG_DST: reg_rdata = 32'(dst_q);
      REG_NXT: reg_rdata = 32'(nxt_q);
      REG_CTL: reg_rdata = ctl_q;
      REG_CFG: begin
        reg_rdata[CFG_EN]   = ch_en;
        reg_rdata[CFG_BUSY] = active;
        reg_rdata[CFG_HALT] = ch_halt;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
  import lldma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_en,
  input  logic             ch_halt,
  input  logic             glb_en,
  input  logic [AW-1:0]    src_q,
  input  logic [AW-1:0]    dst_q,
  input  logic [AW-1:0]    nxt_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [2:0]       sw_q,
  input  logic [2:0]       dw_q,
  input  logic             sinc_q,
  input  logic             dinc_q,
  input  logic             tc_q,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [AW-1:0]    mem_req_addr,
  output logic [1:0]       mem_req_size,
  output logic [31:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  input  logic             mem_rsp_err,
  output logic             src_upd,
  output logic [AW-1:0]    src_nxt,
  output logic             dst_upd,
  output logic [AW-1:0]    dst_nxt,
  output logic             cnt_upd,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             ld_valid,
  output logic [1:0]       ld_idx,
  output logic [31:0]      ld_data,
  output logic             clr_en,
  output logic             active,
  output logic             tc_pulse,
  output logic             err_pulse
);
  lldma_state_e state, nstate;
  logic [31:0]  data_q;
  logic [1:0]   fidx;
  logic [AW-1:0] fbase;
  logic hold, widths_ok;
  logic go_err, go_tc, end_chain, fetch_go, rd_ok, xfer_done;

  assign hold      = ch_halt || !glb_en;
  assign widths_ok = (sw_q <= 3'd2) && (dw_q <= 3'd2);

  lldma_step #(.AW(AW)) u_src_step (
    .addr_i(src_q), .width_i(sw_q[1:0]), .inc_i(sinc_q), .addr_o(src_nxt)
  );
  lldma_step #(.AW(AW)) u_dst_step (
    .addr_i(dst_q), .width_i(dw_q[1:0]), .inc_i(dinc_q), .addr_o(dst_nxt)
  );

  always_comb begin
    nstate    = state;
    go_err    = 1'b0;
    go_tc     = 1'b0;
    end_chain = 1'b0;
    fetch_go  = 1'b0;
    rd_ok     = 1'b0;
    xfer_done = 1'b0;
    ld_valid  = 1'b0;
    unique case (state)
      ST_IDLE:  if (ch_en) nstate = ST_SCHED;
      ST_SCHED: begin
        if (!ch_en) nstate = ST_IDLE;
        else if (!hold) begin
          if (!widths_ok) begin
            go_err = 1'b1;
            nstate = ST_IDLE;
          end else if (cnt_q != '0) begin
            nstate = ST_RD;
          end else begin
            go_tc = tc_q;
            if (nxt_q != '0) begin
              fetch_go = 1'b1;
              nstate   = ST_FQ;
            end else begin
              end_chain = 1'b1;
              nstate    = ST_IDLE;
            end
          end
        end
      end
      ST_RD:  if (mem_req_ready) nstate = ST_RDW;
      ST_RDW: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          go_err = 1'b1;
          nstate = ST_IDLE;
        end else begin
          rd_ok  = 1'b1;
          nstate = ST_WR;
        end
      end
      ST_WR:  if (mem_req_ready) nstate = ST_WRW;
      ST_WRW: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          go_err = 1'b1;
          nstate = ST_IDLE;
        end else begin
          xfer_done = 1'b1;
          nstate    = ST_SCHED;
        end
      end
      ST_FQ:  if (mem_req_ready) nstate = ST_FW;
      ST_FW:  if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          go_err = 1'b1;
          nstate = ST_IDLE;
        end else begin
          ld_valid = 1'b1;
          nstate   = (fidx == 2'd3) ? ST_SCHED : ST_FQ;
        end
      end
      default: nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      data_q    <= '0;
      fidx      <= '0;
      fbase     <= '0;
      tc_pulse  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      state     <= nstate;
      tc_pulse  <= go_tc;
      err_pulse <= go_err;
      if (rd_ok) data_q <= mem_rsp_data & width_mask(sw_q[1:0]);
      if (fetch_go) begin
        fbase <= nxt_q;
        fidx  <= '0;
      end else if (ld_valid) begin
        fidx <= fidx + 2'd1;
      end
    end
  end

  assign ld_idx  = fidx;
  assign ld_data = mem_rsp_data;
  assign src_upd = xfer_done;
  assign dst_upd = xfer_done;
  assign cnt_upd = xfer_done;
  assign cnt_nxt = cnt_q - CNT_W'(1);
  assign clr_en  = go_err || end_chain;
  assign active  = (state != ST_IDLE) && !(state == ST_SCHED && hold);

  assign mem_req_valid = (state == ST_RD) || (state == ST_WR) || (state == ST_FQ);
  assign mem_req_write = (state == ST_WR);
  assign mem_req_wdata = data_q & width_mask(dw_q[1:0]);

  always_comb begin
    case (state)
      ST_WR: begin
        mem_req_addr = dst_q;
        mem_req_size = dw_q[1:0];
      end
      ST_FQ: begin
        mem_req_addr = fbase + AW'({fidx, 2'b00});
        mem_req_size = 2'd2;
      end
      default: begin
        mem_req_addr = src_q;
        mem_req_size = sw_q[1:0];
      end
    endcase
  end
endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
  import lldma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [1:0]      mem_req_size,
  output logic [31:0]     mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  input  logic            mem_rsp_err,
  output logic            tc_pulse,
  output logic            err_pulse
);
  logic [AW-1:0]    src_q, dst_q, nxt_q, src_nxt, dst_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [2:0]       sw_q, dw_q;
  logic             sinc_q, dinc_q, tc_q;
  logic             ch_en, ch_halt, glb_en, chan_active;
  logic             src_upd, dst_upd, cnt_upd, ld_valid, clr_en;
  logic [1:0]       ld_idx;
  logic [31:0]      ld_data;

  lldma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_upd(src_upd), .src_nxt(src_nxt), .dst_upd(dst_upd), .dst_nxt(dst_nxt),
    .cnt_upd(cnt_upd), .cnt_nxt(cnt_nxt),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
    .clr_en(clr_en), .active(chan_active),
    .src_q(src_q), .dst_q(dst_q), .nxt_q(nxt_q), .cnt_q(cnt_q),
    .sw_q(sw_q), .dw_q(dw_q), .sinc_q(sinc_q), .dinc_q(dinc_q), .tc_q(tc_q),
    .ch_en(ch_en), .ch_halt(ch_halt), .glb_en(glb_en)
  );

  lldma_engine #(.AW(AW)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .ch_en(ch_en), .ch_halt(ch_halt), .glb_en(glb_en),
    .src_q(src_q), .dst_q(dst_q), .nxt_q(nxt_q), .cnt_q(cnt_q),
    .sw_q(sw_q), .dw_q(dw_q), .sinc_q(sinc_q), .dinc_q(dinc_q), .tc_q(tc_q),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .src_upd(src_upd), .src_nxt(src_nxt), .dst_upd(dst_upd), .dst_nxt(dst_nxt),
    .cnt_upd(cnt_upd), .cnt_nxt(cnt_nxt),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
    .clr_en(clr_en), .active(chan_active),
    .tc_pulse(tc_pulse), .err_pulse(err_pulse)
  );
endmodule

// File: rtl/lldma_channel_chk.sv
module lldma_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [1:0]    mem_req_size,
  input logic          tc_pulse,
  input logic          err_pulse,
  input logic          ch_en,
  input logic          ch_halt,
  input logic          glb_en,
  input logic          chan_active
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R11
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tc_pulse && err_pulse)); // R11
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_size <= 2'd2); // R6
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !ch_en); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_active |-> !mem_req_valid); // R8
  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_halt || !glb_en) && !chan_active |=> !mem_req_valid); // R9
endmodule

bind lldma_channel lldma_channel_chk #(.AW(AW)) u_chk (.*);

// File: tb/lldma_channel_bench.sv
`timescale 1ns/1ps
module lldma_channel_bench;
  import lldma_pkg::*;
  localparam int AW = 32;
  localparam int MEMB = 1024;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n = 1'b0;

  logic reg_we = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic req_valid, req_ready, req_write, rsp_valid, rsp_err, tc_pulse, err_pulse;
  logic [AW-1:0] req_addr;
  logic [1:0] req_size;
  logic [31:0] req_wdata, rsp_data;

  lldma_channel #(.AW(AW)) u_lldma_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(req_valid), .mem_req_ready(req_ready), .mem_req_write(req_write),
    .mem_req_addr(req_addr), .mem_req_size(req_size), .mem_req_wdata(req_wdata),
    .mem_rsp_valid(rsp_valid), .mem_rsp_data(rsp_data), .mem_rsp_err(rsp_err),
    .tc_pulse(tc_pulse), .err_pulse(err_pulse)
  );

  logic [7:0] mem [MEMB];
  logic [7:0] expm [MEMB];
  logic [7:0] lfsr;
  int vecs = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, tc_cnt = 0, err_cnt = 0, hs_viol = 0;
  logic pend = 1'b0;
  logic [AW-1:0] pend_addr;
  logic pend_wr;

  function automatic logic [31:0] msk(input int w);
    return (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // memory model: response one cycle after acceptance, error above MEMB
  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_data <= '0;
      req_ready <= 1'b0; lfsr <= 8'hA5;
    end else begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      req_ready <= lfsr[0] | lfsr[2];
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      if (req_valid && req_ready) begin
        rsp_valid <= 1'b1;
        if (req_addr >= MEMB) begin
          rsp_err <= 1'b1; rsp_data <= '0;
        end else if (req_write) begin
          for (int i = 0; i < (1 << req_size); i++)
            mem[(int'(req_addr) + i) % MEMB] = req_wdata[8*i +: 8];
        end else begin
          logic [31:0] v;
          v = '0;
          for (int i = 0; i < 4; i++) v[8*i +: 8] = mem[(int'(req_addr) + i) % MEMB];
          rsp_data <= v & msk(int'(req_size));
        end
      end
    end
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && (!req_valid || req_addr != pend_addr || req_write != pend_wr)) hs_viol++;
      pend = req_valid && !req_ready;
      pend_addr = req_addr;
      pend_wr = req_write;
      if (req_valid && req_ready) begin
        if (req_write) wr_cnt++; else rd_cnt++;
      end
      if (tc_pulse) tc_cnt++;
      if (err_pulse) err_cnt++;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [RA_W-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [RA_W-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rreg(REG_CFG, v);
      if (!v[CFG_EN] && !v[CFG_BUSY]) return;
    end
    chk("R4 channel never went idle", 1, 0);
  endtask

  task automatic mem_init();
    for (int i = 0; i < MEMB; i++) mem[i] = 8'(i * 7 + 3);
  endtask

  task automatic put_w(input int a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) mem[a + i] = w[8*i +: 8];
  endtask

  task automatic snap();
    for (int i = 0; i < MEMB; i++) expm[i] = mem[i];
  endtask

  task automatic model_item(input int s, input int d, input int n, input int sw,
                            input int dw, input int si, input int di);
    for (int k = 0; k < n; k++) begin
      int sa, da;
      logic [31:0] v;
      sa = s + (si != 0 ? (k << sw) : 0);
      da = d + (di != 0 ? (k << dw) : 0);
      v = '0;
      for (int b = 0; b < (1 << sw); b++) v[8*b +: 8] = expm[(sa + b) % MEMB];
      for (int b = 0; b < (1 << dw); b++) expm[(da + b) % MEMB] = v[8*b +: 8];
    end
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < MEMB; i++) if (mem[i] !== expm[i]) n++;
    return n;
  endfunction

  function automatic logic [31:0] ctl(input int tc, input int di, input int si,
                                      input int dw, input int sw, input int n);
    return (32'(tc) << CTL_TC) | (32'(di) << CTL_DINC) | (32'(si) << CTL_SINC) |
           (32'(dw) << CTL_DW_L) | (32'(sw) << CTL_SW_L) | 32'(n);
  endfunction

  task automatic prog(input int s, input int d, input int nx, input logic [31:0] c);
    wreg(REG_SRC, 32'(s)); wreg(REG_DST, 32'(d));
    wreg(REG_NXT, 32'(nx)); wreg(REG_CTL, c);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int tc0, rd0, wr0, er0, r1, w1;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state of all registers
    for (int a = 0; a < 6; a++) begin
      rreg(3'(a), v);
      chk($sformatf("R1 reset reg %0d", a), v, 0);
    end
    wreg(REG_GLB, 1);
    rreg(REG_GLB, v); chk("R1 global enable readback", v, 1);

    // R2 R3 R5 sweep over widths, increments and counts
    for (int sw = 0; sw < 3; sw++)
      for (int dw = 0; dw < 3; dw++)
        for (int si = 0; si < 2; si++)
          for (int di = 0; di < 2; di++)
            for (int ci = 0; ci < 3; ci++) begin
              int n, s, d, tcb;
              n = (ci == 2) ? 3 : ci;
              s = 16'h041 + sw * 8; d = 16'h200 + dw * 4;
              tcb = (sw + dw + ci + si) % 2;
              mem_init(); snap();
              tc0 = tc_cnt;
              prog(s, d, 0, ctl(tcb, di, si, dw, sw, n));
              wreg(REG_CFG, 1);
              wait_idle();
              model_item(s, d, n, sw, dw, si, di);
              chk("R2 memory image", mem_diff(), 0);
              rreg(REG_SRC, v); chk("R3 source after item", v, s + (si != 0 ? n << sw : 0));
              rreg(REG_DST, v); chk("R3 destination after item", v, d + (di != 0 ? n << dw : 0));
              rreg(REG_CTL, v); chk("R3 count field", v[10:0], 0);
              chk("R5 terminal-count pulses", tc_cnt - tc0, tcb);
              rreg(REG_CFG, v); chk("R4 enable cleared at chain end", v, 0);
            end

    // R4 chain of three items
    mem_init();
    put_w(12'h300, 32'h020); put_w(12'h304, 32'h220); put_w(12'h308, 32'h310);
    put_w(12'h30C, ctl(0, 1, 1, 2, 2, 3));
    put_w(12'h310, 32'h040); put_w(12'h314, 32'h240); put_w(12'h318, 32'h0);
    put_w(12'h31C, ctl(1, 1, 1, 2, 2, 1));
    snap();
    tc0 = tc_cnt; rd0 = rd_cnt; wr0 = wr_cnt;
    prog(32'h000, 32'h200, 32'h300, ctl(1, 1, 1, 2, 2, 2));
    wreg(REG_CFG, 1);
    wait_idle();
    model_item(32'h000, 32'h200, 2, 2, 2, 1, 1);
    model_item(32'h020, 32'h220, 3, 2, 2, 1, 1);
    model_item(32'h040, 32'h240, 1, 2, 2, 1, 1);
    chk("R4 chain memory image", mem_diff(), 0);
    chk("R4 chain reads incl. descriptors", rd_cnt - rd0, 14);
    chk("R4 chain writes", wr_cnt - wr0, 6);
    chk("R5 chain terminal counts", tc_cnt - tc0, 2);
    rreg(REG_NXT, v); chk("R4 next pointer loaded", v, 0);
    rreg(REG_SRC, v); chk("R4 source from last descriptor", v, 32'h044);

    // R8 halt before start
    mem_init(); snap();
    rd0 = rd_cnt;
    prog(32'h010, 32'h200, 0, ctl(0, 1, 1, 2, 2, 2));
    wreg(REG_CFG, (1 << CFG_HALT) | 1);
    repeat (20) @(negedge clk);
    chk("R8 no request while halted", rd_cnt - rd0, 0);
    rreg(REG_CFG, v);
    chk("R8 busy clear while halted", v[CFG_BUSY], 0);
    chk("R8 enable kept while halted", v[CFG_EN], 1);
    wreg(REG_CFG, 1);
    wait_idle();
    model_item(32'h010, 32'h200, 2, 2, 2, 1, 1);
    chk("R8 resume after halt", mem_diff(), 0);

    // R8 halt in the middle of an item
    mem_init(); snap();
    rd0 = rd_cnt; wr0 = wr_cnt;
    prog(32'h000, 32'h200, 0, ctl(0, 1, 1, 0, 0, 40));
    wreg(REG_CFG, 1);
    for (int i = 0; i < 500 && (rd_cnt - rd0) < 3; i++) @(negedge clk);
    wreg(REG_CFG, (1 << CFG_HALT) | 1);
    repeat (12) @(negedge clk);
    r1 = rd_cnt; w1 = wr_cnt;
    repeat (20) @(negedge clk);
    chk("R8 no new element while halted", (rd_cnt - r1) + (wr_cnt - w1), 0);
    chk("R8 element in flight completed", rd_cnt - rd0, wr_cnt - wr0);
    rreg(REG_CFG, v); chk("R8 busy clear after halt", v[CFG_BUSY], 0);
    wreg(REG_CFG, 1);
    wait_idle();
    model_item(32'h000, 32'h200, 40, 0, 0, 1, 1);
    chk("R8 full item after resume", mem_diff(), 0);

    // R9 controller disabled
    mem_init(); snap();
    wreg(REG_GLB, 0);
    rd0 = rd_cnt;
    prog(32'h008, 32'h208, 0, ctl(0, 1, 1, 1, 1, 3));
    wreg(REG_CFG, 1);
    repeat (20) @(negedge clk);
    chk("R9 no request with controller off", rd_cnt - rd0, 0);
    rreg(REG_CFG, v); chk("R9 busy clear with controller off", v[CFG_BUSY], 0);
    wreg(REG_GLB, 1);
    wait_idle();
    model_item(32'h008, 32'h208, 3, 1, 1, 1, 1);
    chk("R9 progress after controller on", mem_diff(), 0);

    // R10 software stop mid-item
    mem_init(); snap();
    rd0 = rd_cnt; wr0 = wr_cnt;
    prog(32'h000, 32'h200, 0, ctl(0, 1, 1, 0, 0, 100));
    wreg(REG_CFG, 1);
    for (int i = 0; i < 500 && (rd_cnt - rd0) < 5; i++) @(negedge clk);
    wreg(REG_CFG, 0);
    wait_idle();
    w1 = wr_cnt - wr0;
    chk("R10 reads match writes after stop", rd_cnt - rd0, w1);
    chk("R10 stopped early", (w1 < 100) ? 1 : 0, 1);
    rreg(REG_CTL, v); chk("R10 remaining count", v[10:0], 100 - w1);
    rreg(REG_SRC, v); chk("R10 source address kept", v, w1);
    model_item(32'h000, 32'h200, w1, 0, 0, 1, 1);
    chk("R10 memory after stop", mem_diff(), 0);

    // R6 illegal width codes
    for (int k = 0; k < 2; k++) begin
      rd0 = rd_cnt; er0 = err_cnt; tc0 = tc_cnt;
      prog(32'h000, 32'h200, 0, ctl(1, 1, 1, k == 0 ? 3 : 0, k == 0 ? 0 : 3, 1));
      wreg(REG_CFG, 1);
      wait_idle();
      chk("R6 error pulse on illegal width", err_cnt - er0, 1);
      chk("R6 no request on illegal width", rd_cnt - rd0, 0);
      chk("R6 no terminal count on illegal width", tc_cnt - tc0, 0);
    end

    // R7 bus error on source read, destination write, descriptor fetch
    rd0 = rd_cnt; wr0 = wr_cnt; er0 = err_cnt;
    prog(32'h800, 32'h200, 0, ctl(0, 1, 1, 2, 2, 2));
    wreg(REG_CFG, 1); wait_idle();
    chk("R7 read error pulses", err_cnt - er0, 1);
    chk("R7 no write after read error", wr_cnt - wr0, 0);
    chk("R7 single read before stop", rd_cnt - rd0, 1);
    rd0 = rd_cnt; wr0 = wr_cnt; er0 = err_cnt;
    prog(32'h000, 32'h900, 0, ctl(0, 1, 1, 2, 2, 2));
    wreg(REG_CFG, 1); wait_idle();
    chk("R7 write error pulses", err_cnt - er0, 1);
    chk("R7 stop after write error", (rd_cnt - rd0) + (wr_cnt - wr0), 2);
    rd0 = rd_cnt; er0 = err_cnt;
    prog(32'h000, 32'h200, 32'hA00, ctl(0, 1, 1, 2, 2, 0));
    wreg(REG_CFG, 1); wait_idle();
    chk("R7 fetch error pulses", err_cnt - er0, 1);
    chk("R7 stop after fetch error", rd_cnt - rd0, 1);
    rreg(REG_CFG, v); chk("R7 enable cleared by error", v[CFG_EN], 0);

    chk("R11 request held until accepted", hs_viol, 0);

    summary();
    $finish;
  end
endmodule